// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block takes two single-precision IEEE-754 operands and reduces their ordering to a three-bit condition code held in zero, parity and carry flag registers. The overflow, sign and auxiliary flags sit beside them and always read 0. Each operand is classified as NaN, signaling NaN, denormal or zero. Together with a mode input, these classes decide whether an invalid-operation status and a denormal status are raised.

A request is accepted whenever `req_valid` is high; `req_ready` is always high. One cycle later the result appears with `rsp_valid`. The exception status bits are presented on every response. The flags themselves are rewritten only when every raised exception is masked, and `flag_we` marks the cycles in which that happens. When a raised exception is unmasked, the flags keep the value of the last write, so a downstream trap path sees the flags untouched. Decoding, operand fetch and trap delivery belong to the surrounding pipeline.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the written code {zf,pf,cf} is 3'b111.
- R2: When the first operand `op_a` is greater than `op_b`, the written code {zf,pf,cf} is 3'b000.
- R3: When `op_a` is less than `op_b`, the written code {zf,pf,cf} is 3'b001. Ordering is sign-magnitude, so for two negative operands the larger magnitude is the smaller value.
- R4: When the operands are equal, the written code {zf,pf,cf} is 3'b100. Positive and negative zero count as equal.
- R5: `of`, `sf` and `af` read 0 at all times.
- R6: With `quiet_mode` = 0 (signaling compare), `exc_invalid` is raised on a response whose request had any NaN operand.
- R7: With `quiet_mode` = 1 (quiet compare), `exc_invalid` is raised only when an operand is a signaling NaN, that is a NaN with fraction bit 22 clear.
- R8: `exc_denorm` is raised on a response whose request had an operand with exponent zero and a nonzero fraction.
- R9: A mask bit of 1 masks its exception. If a raised exception has its mask bit at 0, `flag_we` stays low and zf, pf and cf keep their previous values. Otherwise the new code is written and `flag_we` is high.
- R10: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. Without a response, `flag_we`, `exc_invalid` and `exc_denorm` are low and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; request accepted |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| quiet_mode | input | 1 | 1 = quiet compare, 0 = signaling compare |
| mask_invalid | input | 1 | 1 masks the invalid-operation exception |
| mask_denorm | input | 1 | 1 masks the denormal exception |
| rsp_valid | output | 1 | Response present |
| flag_we | output | 1 | Flags were written by this response |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always 0 |
| sf | output | 1 | Sign flag, always 0 |
| af | output | 1 | Auxiliary flag, always 0 |
| exc_invalid | output | 1 | Invalid-operation status |
| exc_denorm | output | 1 | Denormal status |

## Verification
Invalid-operation and denormal status can be raised in the same response, for example by a signaling NaN against a denormal, with the two masks set independently. The bench provokes this both in directed cases and through its random operand mix, where each operand is drawn from NaN, denormal, zero and normal classes and each mask bit is drawn on its own. It then checks that both status bits are present and that the flag write is withheld when either one of them is unmasked. After a withheld write, the flags must still show the code of the last written response.

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic                        quiet_mode,
  input  logic                        mask_invalid,
  input  logic                        mask_denorm,
  output logic                        rsp_valid,
  output logic                        flag_we,
  output logic                        zf,
  output logic                        pf,
  output logic                        cf,
  output logic                        of,
  output logic                        sf,
  output logic                        af,
  output logic                        exc_invalid,
  output logic                        exc_denorm
);
  localparam int W   = 1 + EXP_W + FRAC_W;
  localparam int MAG = W - 1;

  logic [EXP_W-1:0]  a_exp, b_exp;
  logic [FRAC_W-1:0] a_frac, b_frac;
  logic [MAG-1:0]    a_mag, b_mag;

  assign a_exp  = op_a[W-2:FRAC_W];
  assign b_exp  = op_b[W-2:FRAC_W];
  assign a_frac = op_a[FRAC_W-1:0];
  assign b_frac = op_b[FRAC_W-1:0];
  assign a_mag  = op_a[MAG-1:0];
  assign b_mag  = op_b[MAG-1:0];

  logic a_nan, b_nan, a_snan, b_snan, a_den, b_den, a_zero, b_zero;
  assign a_nan  = (&a_exp) & (|a_frac);
  assign b_nan  = (&b_exp) & (|b_frac);
  assign a_snan = a_nan & ~a_frac[FRAC_W-1];
  assign b_snan = b_nan & ~b_frac[FRAC_W-1];
  assign a_den  = ~(|a_exp) & (|a_frac);
  assign b_den  = ~(|b_exp) & (|b_frac);
  assign a_zero = ~(|a_mag);
  assign b_zero = ~(|b_mag);

  logic unord, equal, a_greater;
  assign unord = a_nan | b_nan;
  assign equal = (a_zero & b_zero) | (op_a == op_b);

  always_comb begin
    if (op_a[W-1] != op_b[W-1])
      a_greater = ~op_a[W-1];
    else if (op_a[W-1])
      a_greater = a_mag < b_mag;
    else
      a_greater = a_mag > b_mag;
  end

  logic [2:0] code;
  always_comb begin
    if (unord)          code = 3'b111;
    else if (equal)     code = 3'b100;
    else if (a_greater) code = 3'b000;
    else                code = 3'b001;
  end

  logic inv, den, unmasked, accept, write;
  assign inv      = quiet_mode ? (a_snan | b_snan) : unord;
  assign den      = a_den | b_den;
  assign unmasked = (inv & ~mask_invalid) | (den & ~mask_denorm);
  assign req_ready = 1'b1;
  assign accept   = req_valid & req_ready;
  assign write    = accept & ~unmasked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      flag_we     <= 1'b0;
      exc_invalid <= 1'b0;
      exc_denorm  <= 1'b0;
      {zf, pf, cf} <= 3'b000;
    end else begin
      rsp_valid   <= accept;
      flag_we     <= write;
      exc_invalid <= accept & inv;
      exc_denorm  <= accept & den;
      if (write) {zf, pf, cf} <= code;
    end
  end

  assign of = 1'b0;
  assign sf = 1'b0;
  assign af = 1'b0;

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !flag_we && !exc_invalid && !exc_denorm);
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> $stable({zf, pf, cf}));
  a_r9_unmasked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ((exc_invalid && !$past(mask_invalid)) ||
                   (exc_denorm && !$past(mask_denorm)))) |-> !flag_we);
  a_r1_unordered_code: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && zf && pf) |-> cf);
  a_r6_signaling_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && zf && pf && !$past(quiet_mode)) |-> exc_invalid);
endmodule

// File: tb/fcmp_flag_unit_bench.sv
`timescale 1ns/1ps
module fcmp_flag_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic quiet_mode = 1'b0, mask_invalid = 1'b1, mask_denorm = 1'b1;
  logic rsp_valid, flag_we, zf, pf, cf, of, sf, af, exc_invalid, exc_denorm;

  always #10 clk = ~clk;

  fcmp_flag_unit u_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .quiet_mode(quiet_mode),
    .mask_invalid(mask_invalid), .mask_denorm(mask_denorm),
    .rsp_valid(rsp_valid), .flag_we(flag_we), .zf(zf), .pf(pf), .cf(cf),
    .of(of), .sf(sf), .af(af), .exc_invalid(exc_invalid), .exc_denorm(exc_denorm));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [2:0] held = 3'b000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_den(logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 0);
  endfunction

  function automatic logic [2:0] ref_code(logic [31:0] a, logic [31:0] b);
    bit a_gt;
    if (is_nan(a) || is_nan(b)) return 3'b111;
    if ((a[30:0] == 0 && b[30:0] == 0) || a == b) return 3'b100;
    if (a[31] != b[31]) a_gt = !a[31];
    else if (a[31]) a_gt = a[30:0] < b[30:0];
    else a_gt = a[30:0] > b[30:0];
    return a_gt ? 3'b000 : 3'b001;
  endfunction

  function automatic string code_req(logic [2:0] c);
    case (c)
      3'b111: return "R1";
      3'b000: return "R2";
      3'b001: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic issue(logic [31:0] a, logic [31:0] b, bit q, bit mi, bit md);
    logic [2:0] c;
    bit inv, den, wr;
    op_a = a; op_b = b; quiet_mode = q; mask_invalid = mi; mask_denorm = md;
    req_valid = 1'b1;
    c   = ref_code(a, b);
    inv = q ? (is_snan(a) || is_snan(b)) : (is_nan(a) || is_nan(b));
    den = is_den(a) || is_den(b);
    wr  = !((inv && !mi) || (den && !md));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", rsp_valid, 1);
    check(q ? "R7" : "R6", exc_invalid, inv);
    check("R8", exc_denorm, den);
    check("R9", flag_we, wr);
    if (wr) held = c;
    check(wr ? code_req(c) : "R9", {zf, pf, cf}, held);
    check("R5", {of, sf, af}, 3'b000);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    op_a = $urandom; op_b = $urandom;
    @(posedge clk);
    @(negedge clk);
    check("R10", {rsp_valid, flag_we, exc_invalid, exc_denorm}, 4'b0000);
    check("R10", {zf, pf, cf}, held);
  endtask

  function automatic logic [31:0] pick(logic [31:0] other);
    logic [31:0] r = $urandom;
    case ($urandom % 8)
      0: return {r[31], 8'hFF, 1'b1, r[21:0]};
      1: return {r[31], 8'hFF, 1'b0, r[21:0] | 22'h1};
      2: return {r[31], 8'h00, r[22:0] | 23'h1};
      3: return {r[31], 31'h0};
      4: return other;
      5: return {other[31], other[30:0] + {28'h0, r[2:0]} - 31'd4};
      default: return r;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10", {rsp_valid, flag_we, exc_invalid, exc_denorm}, 4'b0000);
    check("R10", {zf, pf, cf}, 3'b000);
    check("R5", {of, sf, af}, 3'b000);
    rst_n = 1'b1;
    check("R10", req_ready, 1);
    issue(32'h4000_0000, 32'h3F80_0000, 0, 1, 1);   // R2 2 > 1
    issue(32'h3F80_0000, 32'h4000_0000, 0, 1, 1);   // R3 1 < 2
    issue(32'hC000_0000, 32'hBF80_0000, 0, 1, 1);   // R3 -2 < -1
    issue(32'hBF80_0000, 32'hC000_0000, 0, 1, 1);   // R2 -1 > -2
    issue(32'h0000_0000, 32'h8000_0000, 0, 0, 0);   // R4 +0 == -0
    issue(32'h7F80_0000, 32'h7F7F_FFFF, 0, 0, 0);   // R2 inf > max
    issue(32'h7FC0_0000, 32'h3F80_0000, 1, 0, 0);   // R7 quiet NaN no invalid, R1
    issue(32'h3F80_0000, 32'h7F80_0001, 1, 1, 1);   // R7 SNaN invalid masked
    issue(32'h3F80_0000, 32'h4000_0000, 0, 1, 1);
    issue(32'h7FC0_0000, 32'h3F80_0000, 0, 0, 1);   // R6 unmasked: flags hold R9
    idle();
    issue(32'h0000_0001, 32'h0000_0002, 0, 1, 0);   // R8 unmasked denorm, hold
    issue(32'h0000_0001, 32'h0000_0002, 0, 1, 1);   // R8 masked, R3
    issue(32'h7F80_0001, 32'h0000_0001, 0, 1, 0);   // both raised, denorm unmasked
    issue(32'h7F80_0001, 32'h0000_0001, 1, 0, 1);   // both raised, invalid unmasked
    issue(32'h7F80_0001, 32'h0000_0001, 1, 1, 1);   // both masked, R1
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) begin
        idle();
      end else begin
        a = pick($urandom);
        b = pick(a);
        if (r[4]) begin
          logic [31:0] t = a; a = b; b = t;
        end
        issue(a, b, r[5], r[6] | r[8], r[7] | r[9]);
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10: watchdog expired, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule